// File: doc/BRIEF.md
# Byte-Addressed SPI Register Slave

This block is the serial host port of a sensor front end. An external SPI master reaches a bank of 16-bit registers through it. Each register answers to two byte addresses: the even one names the low byte and the odd one names the high byte. A write frame changes exactly one byte. A read frame names a register, and the whole 16-bit word comes back on the data output during the next frame. The block runs in the system clock domain and oversamples the SPI pins through a synchronizer, so SCLK must be several times slower than the system clock.

There are three register classes:
- Output data registers take fresh samples from the sensor datapath over a valid/ready stream. Each word carries a new-data flag in bit 15, an error flag in bit 14 and a 14-bit value in bits 13:0.
- Control registers are written over SPI and drive the control output bus.
- One status register holds latched flags, which clear when the register is read, and live flags, which follow their inputs.

A frame that does not have exactly 16 clocks is dropped and raises a communication-error flag.

Stream rules for the sample input: the producer holds `upd_valid`, `upd_idx` and `upd_value` steady until it sees `upd_ready` high at a rising clock edge. `upd_ready` drops for exactly one cycle: the cycle in which the register named by `upd_idx` is being copied out for a read. In that cycle the read clears the register's new-data flag. The stalled update lands one cycle later and sets the flag again, so no sample is lost and no flag is cleared wrongly.

Top module: `spireg_slave`

## Requirements
- R1: A frame is 16 SCLK cycles while CS is low, MSB first. DIN carries, in order: the direction bit (1 = write, 0 = read), a reserved bit, a 6-bit byte address, then 8 data bits. A frame with the reserved bit at 1 neither writes nor schedules a read.
- R2: A write frame updates only one byte of the addressed control register: the high byte when address bit 0 is 1, the low byte when it is 0. The other byte keeps its value. Control word k sits at byte addresses 2*(8+k) and 2*(8+k)+1, and all control words reset to zero.
- R3: After a read frame at either byte address of a register, the following frame shifts out the full 16-bit word on DOUT.
- R4: A frame that was not preceded by a completed read frame shifts out all zeros.
- R5: While CS is high, the output enable is low, DOUT is 0, and SCLK and DIN change no state. The output enable is high while CS is low.
- R6: SPI mode 3 timing applies. The word's MSB is on DOUT from the CS falling edge, DOUT advances after each SCLK falling edge except the first, and DIN is sampled on SCLK rising edges.
- R7: Data word d (byte addresses 2d and 2d+1, d = 0..3) reads as {new-data, error, value[13:0]}. New-data is set when a sample is accepted and cleared once the word has been read out. The error bit is 1 whenever any status bit is 1.
- R8: The status word sits at byte addresses 0x3C/0x3D. Bit 0 is a latched communication error and bit 1 a latched alarm; both clear when the word is read. Bit 2 (supply out of range) and bit 3 (over-range) follow their inputs live. All other bits are 0.
- R9: A frame with fewer or more than 16 clocks is discarded without a write and sets status bit 0.
- R10: The word returned for a read is captured at the CS falling edge of the following frame. A sample accepted during that frame does not change the word being shifted out.
- R11: A sample is accepted when `upd_valid` and `upd_ready` are both high at a clock edge. `upd_ready` is high except in the one cycle when its target register is captured for a read.
- R12: Writes to data, status or unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from master, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Enable for the external tri-state driver of spi_miso |
| upd_valid | input | 1 | Sample stream valid |
| upd_ready | output | 1 | Sample stream ready |
| upd_idx | input | 2 | Target data register of the sample |
| upd_value | input | 14 | Sample value |
| alarm_pulse | input | 1 | One-cycle alarm event, latched into status |
| flag_supply | input | 1 | Live supply-out-of-range condition |
| flag_range | input | 1 | Live over-range condition |
| ctrl_q | output | 64 | Control registers, word k at bits 16k+15:16k |

## Verification
A wrong pending-read index or a stale capture shows up as a wrong word on DOUT in the very next frame. A lost byte lane shows up on `ctrl_q` a few system clocks after CS rises. Flag errors take one more read to surface: a new-data or latched status bit that fails to clear appears in the second consecutive read of the same word. A flag that clears too eagerly appears as bit 15 or bit 14 missing on the first read after a sample or fault. A frame-length miscount shows only as a control byte that changed when it should not have, plus status bit 0, so every discarded frame is followed by a control readback and a status read.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int REG_W      = 16;
  localparam int VAL_W      = REG_W - 2;
  localparam int WORD_W     = ADDR_W - 1;

  typedef struct packed {
    logic              wr;
    logic              rsv;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } spi_cmd_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s
);
  // Bit order inside each stage: {sclk, cs_n, mosi}; idle levels 1,1,0.
  localparam logic [2:0] IDLE = 3'b110;

  logic [STAGES-1:0][2:0] chain;
  logic [2:0]             last, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE}};
      prev  <= IDLE;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) chain[s] <= chain[s-1];
      chain[0] <= {sclk, cs_n, mosi};
      prev     <= chain[STAGES-1];
    end
  end

  assign last      = chain[STAGES-1];
  assign sclk_rise = last[2] & ~prev[2];
  assign sclk_fall = ~last[2] & prev[2];
  assign cs_s      = last[1];
  assign cs_fall   = ~last[1] & prev[1];
  assign cs_rise   = last[1] & ~prev[1];
  assign mosi_s    = last[0];
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              mosi_s,
  input  logic [REG_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_idx,
  output logic              rd_clr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frame_err,
  output logic              miso,
  output logic              miso_oe
);
  localparam int               CNT_W   = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  pend_vld;
  logic [WORD_W-1:0]     pend_idx;
  spi_cmd_t              cmd;

  assign cmd    = spi_cmd_t'(rx_sr);
  assign rd_idx = pend_idx;
  assign rd_clr = cs_fall & pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      tx_sr     <= '0;
      bit_cnt   <= '0;
      pend_vld  <= 1'b0;
      pend_idx  <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      frame_err <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      frame_err <= 1'b0;
      if (cs_fall) begin
        // capture read word now so mid-frame sample updates cannot corrupt it
        tx_sr    <= pend_vld ? rd_word : '0;
        pend_vld <= 1'b0;
        bit_cnt  <= '0;
      end else if (!cs_s) begin
        if (sclk_rise) begin
          rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sclk_fall && bit_cnt != '0) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
      end
      if (cs_rise) begin
        if (bit_cnt == CNT_END) begin
          if (!cmd.rsv) begin
            if (cmd.wr) begin
              wr_en   <= 1'b1;
              wr_addr <= cmd.addr;
              wr_data <= cmd.data;
            end else begin
              pend_vld <= 1'b1;
              pend_idx <= cmd.addr[ADDR_W-1:1];
            end
          end
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

  assign miso_oe = ~cs_s;
  assign miso    = tx_sr[FRAME_BITS-1] & ~cs_s;

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_MAX);
  a_r9_error_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !wr_en);
  a_r10_tx_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_fall) |=> $stable(tx_sr));
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
#(
  parameter int N_DATA    = 4,   // at least 2
  parameter int N_CTRL    = 4,
  parameter int CTRL_BASE = 8,
  parameter int STAT_WORD = 30,
  localparam int IDX_W    = $clog2(N_DATA)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [WORD_W-1:0]       rd_idx,
  input  logic                    rd_clr,
  output logic [REG_W-1:0]        rd_word,
  input  logic                    upd_valid,
  output logic                    upd_ready,
  input  logic [IDX_W-1:0]        upd_idx,
  input  logic [VAL_W-1:0]        upd_value,
  input  logic                    frame_err,
  input  logic                    alarm_pulse,
  input  logic                    flag_supply,
  input  logic                    flag_range,
  output logic [N_CTRL*REG_W-1:0] ctrl_q
);
  logic [N_DATA-1:0][VAL_W-1:0] data_val;
  logic [N_DATA-1:0]            data_nd;
  logic [N_CTRL-1:0][REG_W-1:0] ctrl_r;
  logic                         st_comm, st_alarm, any_err, stat_rd;
  logic [WORD_W-1:0]            wr_word;

  assign wr_word   = wr_addr[ADDR_W-1:1];
  assign stat_rd   = rd_clr && rd_idx == WORD_W'(STAT_WORD);
  assign any_err   = st_comm | st_alarm | flag_supply | flag_range;
  assign upd_ready = !(rd_clr && rd_idx == WORD_W'(upd_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_val <= '0;
      data_nd  <= '0;
    end else begin
      for (int i = 0; i < N_DATA; i++) begin
        if (upd_valid && upd_ready && upd_idx == IDX_W'(i)) begin
          data_val[i] <= upd_value;
          data_nd[i]  <= 1'b1;
        end else if (rd_clr && rd_idx == WORD_W'(i)) begin
          data_nd[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_CTRL; i++) begin
        if (wr_word == WORD_W'(CTRL_BASE + i)) begin
          if (wr_addr[0]) ctrl_r[i][REG_W-1:BYTE_W] <= wr_data;
          else            ctrl_r[i][BYTE_W-1:0]     <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_comm  <= 1'b0;
      st_alarm <= 1'b0;
    end else if (stat_rd) begin
      st_comm  <= frame_err;
      st_alarm <= alarm_pulse;
    end else begin
      if (frame_err)   st_comm  <= 1'b1;
      if (alarm_pulse) st_alarm <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_DATA; i++)
      if (rd_idx == WORD_W'(i)) rd_word = {data_nd[i], any_err, data_val[i]};
    for (int i = 0; i < N_CTRL; i++)
      if (rd_idx == WORD_W'(CTRL_BASE + i)) rd_word = ctrl_r[i];
    if (rd_idx == WORD_W'(STAT_WORD))
      rd_word = {{(REG_W-4){1'b0}}, flag_range, flag_supply, st_alarm, st_comm};
  end

  assign ctrl_q = ctrl_r;

  a_r7_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> data_nd[$past(upd_idx)]);
  a_r7_readout_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && rd_idx < WORD_W'(N_DATA)) |=> !data_nd[$past(rd_idx[IDX_W-1:0])]);
  a_r2_ctrl_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_r));
  a_r8_comm_error_latches: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> st_comm);
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_DATA      = 4,
  parameter int N_CTRL      = 4,
  parameter int CTRL_BASE   = 8,
  parameter int STAT_WORD   = 30,
  localparam int IDX_W      = $clog2(N_DATA)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  input  logic                    upd_valid,
  output logic                    upd_ready,
  input  logic [IDX_W-1:0]        upd_idx,
  input  logic [VAL_W-1:0]        upd_value,
  input  logic                    alarm_pulse,
  input  logic                    flag_supply,
  input  logic                    flag_range,
  output logic [N_CTRL*REG_W-1:0] ctrl_q
);
  logic              sclk_rise, sclk_fall, cs_s, cs_fall, cs_rise, mosi_s;
  logic [REG_W-1:0]  rd_word;
  logic [WORD_W-1:0] rd_idx;
  logic              rd_clr, wr_en, frame_err;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_s(cs_s),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spireg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_s(cs_s), .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s),
    .rd_word(rd_word), .rd_idx(rd_idx), .rd_clr(rd_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_err(frame_err), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spireg_bank #(
    .N_DATA(N_DATA), .N_CTRL(N_CTRL), .CTRL_BASE(CTRL_BASE), .STAT_WORD(STAT_WORD)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_clr(rd_clr), .rd_word(rd_word),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_idx(upd_idx),
    .upd_value(upd_value), .frame_err(frame_err), .alarm_pulse(alarm_pulse),
    .flag_supply(flag_supply), .flag_range(flag_range), .ctrl_q(ctrl_q)
  );

  a_r5_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);
endmodule

// File: tb/test_spireg_slave.sv
`timescale 1ns/1ps
module test_spireg_slave;
  localparam int H = 8;
  localparam logic [15:0] NULL_CMD = 16'h4000;
  localparam logic [5:0]  STAT_A   = 6'h3C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, upd_ready;
  logic        upd_valid = 1'b0, alarm_pulse = 1'b0, flag_supply = 1'b0, flag_range = 1'b0;
  logic [1:0]  upd_idx = '0;
  logic [13:0] upd_value = '0;
  logic [63:0] ctrl_q;
  int checks = 0, failures = 0;
  logic [15:0] exp_ctrl [4];
  logic [13:0] exp_val [4];

  always #2 clk = ~clk;

  spireg_slave i_spireg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_idx(upd_idx), .upd_value(upd_value), .alarm_pulse(alarm_pulse),
    .flag_supply(flag_supply), .flag_range(flag_range), .ctrl_q(ctrl_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [15:0] tx, input int nclk, input bit mid_upd,
                          input logic [1:0] m_idx, input logic [13:0] m_val,
                          output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sclk = 1'b1;
      if (mid_upd && i == 8) begin
        upd_idx = m_idx; upd_value = m_val; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        repeat (H-1) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
    end
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
    spi_xfer(tx, 16, 1'b0, 2'd0, 14'd0, rx);
  endtask

  task automatic write_byte(input logic [5:0] a, input logic [7:0] d);
    logic [15:0] dummy;
    xfer({2'b10, a, d}, dummy);
  endtask

  task automatic read_reg(input logic [5:0] a, output logic [15:0] w);
    logic [15:0] dummy;
    xfer({2'b00, a, 8'hC3}, dummy);
    xfer(NULL_CMD, w);
  endtask

  task automatic push(input logic [1:0] idx, input logic [13:0] v);
    @(negedge clk);
    upd_idx = idx; upd_value = v; upd_valid = 1'b1;
    while (!upd_ready) @(negedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic check_ctrl(input string req);
    for (int r = 0; r < 4; r++) check(req, ctrl_q[r*16 +: 16], exp_ctrl[r]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] w, dummy;
    for (int r = 0; r < 4; r++) exp_ctrl[r] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R5 oe idle after reset", miso_oe, 0);
    check("R2 ctrl reset", ctrl_q, 0);
    check("R11 ready idle", upd_ready, 1);

    // R2/R3/R6: byte writes and full-word reads over every control word
    for (int r = 0; r < 4; r++) begin
      logic [7:0] lo, hi;
      lo = 8'(17 * (r + 1));
      hi = 8'(8'hA0 + r);
      write_byte(6'(16 + 2*r), lo);
      exp_ctrl[r][7:0] = lo;
      check_ctrl("R2 low byte only");
      write_byte(6'(17 + 2*r), hi);
      exp_ctrl[r][15:8] = hi;
      check_ctrl("R2 high byte only");
      read_reg(6'(16 + 2*r), w);
      check("R3 read via low address", w, {hi, lo});
      check("R6 msb driven at frame start", w[15], 1);
      read_reg(6'(17 + 2*r), w);
      check("R3 read via high address", w, {hi, lo});
    end
    write_byte(6'd20, 8'h5A);
    exp_ctrl[2][7:0] = 8'h5A;
    check_ctrl("R2 partial overwrite keeps high byte");

    // R4: frame after a write returns zeros
    xfer({2'b10, 6'd16, 8'h11}, dummy);
    xfer(NULL_CMD, w);
    check("R4 zero after non-read", w, 0);

    // R7: data registers, flags and values
    for (int d = 0; d < 4; d++) begin
      exp_val[d] = 14'((d + 1) * 1092 + (d % 2) * 8192);
      push(2'(d), exp_val[d]);
      read_reg(6'(2*d), w);
      check("R7 fresh sample flagged", w, {2'b10, exp_val[d]});
      read_reg(6'(2*d + 1), w);
      check("R7 flag cleared after read", w, {2'b00, exp_val[d]});
    end

    // R12: writes outside control space ignored
    write_byte(6'd3, 8'hFF);
    write_byte(6'd2, 8'h00);
    write_byte(STAT_A, 8'hFF);
    write_byte(6'h30, 8'h77);
    check_ctrl("R12 ctrl untouched");
    read_reg(6'd2, w);
    check("R12 data word untouched", w, {2'b00, exp_val[1]});
    read_reg(STAT_A, w);
    check("R12 status untouched", w, 0);

    // R5: SCLK/DIN activity while deselected
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; mosi = i[0];
      repeat (H) @(negedge clk);
      if (i == 3) check("R5 oe low while deselected", miso_oe, 0);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    check_ctrl("R5 no write while deselected");
    read_reg(STAT_A, w);
    check("R5 no error while deselected", w, 0);

    // R10: sample during readout frame does not change shifted word
    push(2'd1, 14'h0AAA);
    xfer({2'b00, 6'd2, 8'h00}, dummy);
    spi_xfer(NULL_CMD, 16, 1'b1, 2'd1, 14'h3DDE, w);
    check("R10 captured word kept", w, {2'b10, 14'h0AAA});
    read_reg(6'd2, w);
    check("R10 mid-frame sample visible next", w, {2'b10, 14'h3DDE});

    // R1: reserved bit set makes a no-op
    xfer({2'b11, 6'd16, 8'hEE}, dummy);
    check_ctrl("R1 reserved bit write ignored");
    xfer({2'b01, 6'd16, 8'h00}, dummy);
    xfer(NULL_CMD, w);
    check("R1 reserved bit read ignored", w, 0);

    // R9: zero-clock, short and long frames
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    check("R5 oe high while selected", miso_oe, 1);
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
    read_reg(STAT_A, w);
    check("R9 empty frame flags error", w, 16'h0001);
    read_reg(STAT_A, w);
    check("R8 latched error cleared by read", w, 0);
    spi_xfer({2'b10, 6'd16, 8'h55}, 10, 1'b0, 2'd0, 14'd0, dummy);
    check_ctrl("R9 short frame discarded");
    push(2'd0, 14'h1234);
    read_reg(6'd0, w);
    check("R7 error bit follows status", w, {2'b11, 14'h1234});
    read_reg(STAT_A, w);
    check("R9 short frame flags error", w, 16'h0001);
    spi_xfer({2'b10, 6'd17, 8'h55}, 17, 1'b0, 2'd0, 14'd0, dummy);
    check_ctrl("R9 long frame discarded");
    read_reg(STAT_A, w);
    check("R9 long frame flags error", w, 16'h0001);

    // R8: alarm latch and live flags
    @(negedge clk); alarm_pulse = 1'b1;
    @(negedge clk); alarm_pulse = 1'b0;
    read_reg(STAT_A, w);
    check("R8 alarm latched", w, 16'h0002);
    read_reg(STAT_A, w);
    check("R8 alarm cleared", w, 0);
    flag_supply = 1'b1;
    read_reg(STAT_A, w);
    check("R8 supply live", w, 16'h0004);
    read_reg(6'h3D, w);
    check("R8 supply not cleared by read", w, 16'h0004);
    flag_supply = 1'b0; flag_range = 1'b1;
    read_reg(STAT_A, w);
    check("R8 range live", w, 16'h0008);
    flag_range = 1'b0;
    read_reg(STAT_A, w);
    check("R8 live flags drop", w, 0);
    check("R11 ready idle at end", upd_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule